// File: doc/BRIEF.md
# Relocatable Interrupt Vector Address Generator

This block turns a reset event and a set of pending interrupt requests into the program address a small microcontroller core fetches next. When the core raises its acknowledge strobe, the block selects one winner: a pending reset if there is one, otherwise the lowest-numbered pending interrupt. It then presents the target word address and the winner's table offset on registered outputs. For an interrupt win it also sends a single-cycle clear pulse back to that one request line.

Each entry of the vector table is one instruction word. Offset 0 holds the reset entry, and request line k (k = 0 .. 24) owns offset k+1, so the offsets run from 0x001 to 0x019. Two independent controls place the table. An active-low boot fuse moves the reset entry from word 0 to the boot section start. A relocation bit moves the interrupt entries to the boot section start plus their offset. Together they give four placements. The core supplies the boot section start, which is 0xC00 for a 2K-byte boot area, so relocated interrupt entries then occupy 0xC01 to 0xC19.

Top module: `irq_vector_gen`

## Requirements
- R1: While rst_n is low and on the first cycle after it, vec_valid is 0, vec_addr and vec_index are 0, and irq_clr is all zero.
- R2: Outputs are registered. A decision taken while ack is high appears on the cycle after that strobe. On any cycle that does not follow an ack, vec_valid is 0 and irq_clr is all zero.
- R3: When ack and reset_evt are both high and boot_rst_n is 1 (fuse unprogrammed), the next cycle shows vec_valid=1, vec_index=0 and vec_addr=0x000.
- R4: When ack and reset_evt are both high and boot_rst_n is 0 (fuse programmed), the next cycle shows vec_valid=1, vec_index=0 and vec_addr=boot_base.
- R5: A reset event wins over every pending interrupt and is taken even when gie is 0. A reset win produces no clear pulse.
- R6: When several enabled requests are pending, the lowest bit wins. vec_index reports that bit number plus 1, so bit 0 gives 1 and bit 24 gives 0x19.
- R7: With vec_sel=0, an interrupt win gives vec_addr equal to vec_index (0x001 to 0x019).
- R8: With vec_sel=1, an interrupt win gives vec_addr = boot_base + vec_index. With boot_base = 0xC00 this is 0xC01 to 0xC19.
- R9: The fuse has no effect on interrupt addresses, and vec_sel has no effect on the reset address.
- R10: While gie is 0, pending requests are ignored: an ack gives vec_valid=0 and no clear pulse.
- R11: After an interrupt win, irq_clr has exactly the winning bit set for exactly one cycle.
- R12: An ack with no reset event and no enabled request gives vec_valid=0 and irq_clr=0, and vec_addr and vec_index keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack | input | 1 | Core strobe asking for the next vector |
| reset_evt | input | 1 | A reset is pending and must be vectored |
| gie | input | 1 | Global interrupt enable |
| irq_req | input | NUM_IRQ | Interrupt request lines; bit k owns table offset k+1 |
| boot_rst_n | input | 1 | Boot reset fuse, 0 = programmed |
| vec_sel | input | 1 | 1 relocates interrupt entries to the boot section |
| boot_base | input | ADDR_W | Boot section start word address |
| vec_valid | output | 1 | One-cycle pulse: vec_addr/vec_index hold a fresh winner |
| vec_addr | output | ADDR_W | Word address to fetch |
| vec_index | output | IDX_W | Table offset of the winner (0 = reset) |
| irq_clr | output | NUM_IRQ | One-hot, one-cycle clear for the winning request |

## Verification
The assertions check the per-cycle invariants on every cycle. The clear vector is one-hot or zero, and it only marks a line that was requested. Nothing is emitted without a preceding ack. A reset with ack always yields offset 0 and no clear. A disabled, reset-free ack yields nothing. An unrelocated interrupt address equals its offset. The directed scenarios are the only way to show the exact placement values for each fuse and relocation combination, the ordering among many simultaneous requests, the end entries at offsets 0x001 and 0x019, and that addresses are held across an empty acknowledge.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    // Outcome of one acknowledge decision
    typedef enum logic [1:0] {
        VK_NONE  = 2'd0,
        VK_RESET = 2'd1,
        VK_IRQ   = 2'd2
    } vec_kind_e;

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_IRQ = 25,
    parameter int IDX_W   = $clog2(NUM_IRQ + 1)
) (
    input  logic [NUM_IRQ-1:0] req,
    output logic               found,
    output logic [IDX_W-1:0]   idx,
    output logic [NUM_IRQ-1:0] onehot
);

    // Lowest set bit wins; its table offset is bit number + 1
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i + 1);
            end
        end
    end

    // Isolate the lowest set bit
    assign onehot = req & (~req + NUM_IRQ'(1));

endmodule

// File: rtl/vec_addr_map.sv
module vec_addr_map
    import irq_vec_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 5
) (
    input  vec_kind_e          kind,
    input  logic               boot_rst_n,
    input  logic               vec_sel,
    input  logic [ADDR_W-1:0]  boot_base,
    input  logic [IDX_W-1:0]   idx,
    output logic [ADDR_W-1:0]  addr
);

    logic [ADDR_W-1:0] base;

    always_comb begin
        unique case (kind)
            VK_RESET: base = boot_rst_n ? '0 : boot_base;
            VK_IRQ:   base = vec_sel ? boot_base : '0;
            default:  base = '0;
        endcase
        addr = base + ADDR_W'(idx);
    end

endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
    import irq_vec_pkg::*;
#(
    parameter int NUM_IRQ = 25,
    parameter int ADDR_W  = 12,
    localparam int IDX_W  = $clog2(NUM_IRQ + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ack,
    input  logic               reset_evt,
    input  logic               gie,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               boot_rst_n,
    input  logic               vec_sel,
    input  logic [ADDR_W-1:0]  boot_base,
    output logic               vec_valid,
    output logic [ADDR_W-1:0]  vec_addr,
    output logic [IDX_W-1:0]   vec_index,
    output logic [NUM_IRQ-1:0] irq_clr
);

    typedef struct packed {
        logic               valid;
        logic [ADDR_W-1:0]  addr;
        logic [IDX_W-1:0]   idx;
        logic [NUM_IRQ-1:0] clr;
    } vec_state_t;

    vec_state_t         st_d, st_q;
    logic [NUM_IRQ-1:0] masked_req;
    logic               pick_found;
    logic [IDX_W-1:0]   pick_idx;
    logic [NUM_IRQ-1:0] pick_onehot;
    vec_kind_e          kind;
    logic [IDX_W-1:0]   map_idx;
    logic [ADDR_W-1:0]  map_addr;

    assign masked_req = gie ? irq_req : '0;

    irq_prio_pick #(
        .NUM_IRQ (NUM_IRQ),
        .IDX_W   (IDX_W)
    ) u_pick (
        .req    (masked_req),
        .found  (pick_found),
        .idx    (pick_idx),
        .onehot (pick_onehot)
    );

    vec_addr_map #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_map (
        .kind       (kind),
        .boot_rst_n (boot_rst_n),
        .vec_sel    (vec_sel),
        .boot_base  (boot_base),
        .idx        (map_idx),
        .addr       (map_addr)
    );

    always_comb begin
        if (!ack)            kind = VK_NONE;
        else if (reset_evt)  kind = VK_RESET;
        else if (pick_found) kind = VK_IRQ;
        else                 kind = VK_NONE;

        map_idx = (kind == VK_IRQ) ? pick_idx : '0;

        st_d       = st_q;
        st_d.valid = (kind != VK_NONE);
        st_d.clr   = (kind == VK_IRQ) ? pick_onehot : '0;
        if (kind != VK_NONE) begin
            st_d.addr = map_addr;
            st_d.idx  = map_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vec_valid = st_q.valid;
    assign vec_addr  = st_q.addr;
    assign vec_index = st_q.idx;
    assign irq_clr   = st_q.clr;

endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk #(
    parameter int NUM_IRQ = 25,
    parameter int ADDR_W  = 12,
    localparam int IDX_W  = $clog2(NUM_IRQ + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ack,
    input logic               reset_evt,
    input logic               gie,
    input logic [NUM_IRQ-1:0] irq_req,
    input logic               vec_sel,
    input logic               vec_valid,
    input logic [ADDR_W-1:0]  vec_addr,
    input logic [IDX_W-1:0]   vec_index,
    input logic [NUM_IRQ-1:0] irq_clr
);

    assert_clr_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_clr));

    assert_clr_was_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr != '0) |-> (($past(irq_req) & irq_clr) == irq_clr));

    assert_quiet_without_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> (!vec_valid && irq_clr == '0));

    assert_reset_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && reset_evt) |=> (vec_valid && vec_index == '0 && irq_clr == '0));

    assert_masked_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !reset_evt && !gie) |=> (!vec_valid && irq_clr == '0));

    assert_plain_table_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !reset_evt && !vec_sel) |=>
            (!vec_valid || vec_addr == ADDR_W'(vec_index)));

endmodule

bind irq_vector_gen irq_vec_chk #(
    .NUM_IRQ (NUM_IRQ),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack),
    .reset_evt (reset_evt),
    .gie       (gie),
    .irq_req   (irq_req),
    .vec_sel   (vec_sel),
    .vec_valid (vec_valid),
    .vec_addr  (vec_addr),
    .vec_index (vec_index),
    .irq_clr   (irq_clr)
);

// File: tb/irq_vector_gen_test.sv
`timescale 1ns/1ps
module irq_vector_gen_test;

    localparam int NUM_IRQ = 25;
    localparam int ADDR_W  = 12;
    localparam int IDX_W   = $clog2(NUM_IRQ + 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ack = 1'b0;
    logic               reset_evt = 1'b0;
    logic               gie = 1'b0;
    logic [NUM_IRQ-1:0] irq_req = '0;
    logic               boot_rst_n = 1'b1;
    logic               vec_sel = 1'b0;
    logic [ADDR_W-1:0]  boot_base = 12'hC00;
    logic               vec_valid;
    logic [ADDR_W-1:0]  vec_addr;
    logic [IDX_W-1:0]   vec_index;
    logic [NUM_IRQ-1:0] irq_clr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    irq_vector_gen #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .ack(ack), .reset_evt(reset_evt), .gie(gie),
        .irq_req(irq_req), .boot_rst_n(boot_rst_n), .vec_sel(vec_sel),
        .boot_base(boot_base), .vec_valid(vec_valid), .vec_addr(vec_addr),
        .vec_index(vec_index), .irq_clr(irq_clr)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected offset of the lowest pending bit (0 if none)
    function automatic int low_off(logic [NUM_IRQ-1:0] r);
        for (int i = 0; i < NUM_IRQ; i++) if (r[i]) return i + 1;
        return 0;
    endfunction

    // Strobe ack for one cycle; returns at the negedge after the sampling edge
    task automatic pulse_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R1 valid in reset", vec_valid, 0);
        check("R1 addr in reset", vec_addr, 0);
        check("R1 clr in reset", irq_clr, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 index after reset", vec_index, 0);
        check("R2 no valid without ack", vec_valid, 0);
    endtask

    task automatic t_reset_place();
        for (int f = 0; f < 2; f++) begin
            for (int s = 0; s < 2; s++) begin
                boot_rst_n = f[0]; vec_sel = s[0]; reset_evt = 1'b1;
                pulse_ack();
                reset_evt = 1'b0;
                check("R3/R4 reset valid", vec_valid, 1);
                check("R3/R4 reset index", vec_index, 0);
                // R9: vec_sel does not move the reset entry
                check(f ? "R3 reset addr" : "R4 reset addr",
                      vec_addr, f ? 0 : 32'(boot_base));
            end
        end
        boot_rst_n = 1'b1; vec_sel = 1'b0;
    endtask

    task automatic t_plain_table();
        logic [NUM_IRQ-1:0] pats [4];
        pats[0] = 25'h0000001;
        pats[1] = 25'h1000000;
        pats[2] = 25'h0F0A000;
        pats[3] = 25'h1000110;
        gie = 1'b1;
        for (int p = 0; p < 4; p++) begin
            irq_req = pats[p];
            pulse_ack();
            check("R6 valid", vec_valid, 1);
            check("R6 lowest wins", vec_index, low_off(pats[p]));
            check("R7 unrelocated addr", vec_addr, low_off(pats[p]));
            check("R11 clear bit", irq_clr, 32'(1) << (low_off(pats[p]) - 1));
            @(negedge clk);
            check("R11 clear lasts one cycle", irq_clr, 0);
        end
        irq_req = '0;
    endtask

    task automatic t_relocated();
        gie = 1'b1; vec_sel = 1'b1;
        for (int f = 0; f < 2; f++) begin
            boot_rst_n = f[0];
            irq_req = 25'h1000000;
            pulse_ack();
            check("R8 top entry relocated", vec_addr, 12'hC19);
            irq_req = 25'h0000003;
            pulse_ack();
            check("R8/R9 first entry relocated", vec_addr, 12'hC01);
        end
        boot_base = 12'h800; irq_req = 25'h0000040;
        pulse_ack();
        check("R8 other base", vec_addr, 12'h807);
        boot_base = 12'hC00; boot_rst_n = 1'b0; vec_sel = 1'b0;
        pulse_ack();
        check("R9 fuse ignored for irq", vec_addr, 12'h007);
        boot_rst_n = 1'b1; irq_req = '0;
    endtask

    task automatic t_gie_off();
        gie = 1'b0; irq_req = 25'h0000F00;
        pulse_ack();
        check("R10 masked valid", vec_valid, 0);
        check("R10 masked clear", irq_clr, 0);
        irq_req = '0; gie = 1'b1;
    endtask

    task automatic t_reset_wins();
        for (int g = 0; g < 2; g++) begin
            gie = g[0]; irq_req = 25'h0000001; reset_evt = 1'b1; boot_rst_n = 1'b0;
            pulse_ack();
            reset_evt = 1'b0;
            check("R5 reset index", vec_index, 0);
            check("R5 reset addr", vec_addr, 12'hC00);
            check("R5 no clear on reset", irq_clr, 0);
        end
        irq_req = '0; boot_rst_n = 1'b1; gie = 1'b1;
    endtask

    task automatic t_empty_ack();
        irq_req = 25'h0000100;
        pulse_ack();
        irq_req = '0;
        pulse_ack();
        check("R12 empty valid", vec_valid, 0);
        check("R12 empty clear", irq_clr, 0);
        check("R12 addr held", vec_addr, 12'h009);
        check("R12 index held", vec_index, 9);
        irq_req = 25'h0000004;
        repeat (3) @(negedge clk);
        check("R2 requests without ack", vec_valid, 0);
        check("R2 no clear without ack", irq_clr, 0);
        irq_req = '0;
    endtask

    initial begin
        t_reset_state();
        t_reset_place();
        t_plain_table();
        t_relocated();
        t_gie_off();
        t_reset_wins();
        t_empty_ack();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule